// File: doc/BRIEF.md
# Nibble Rotate Unit with Data-Indexed Source Addressing

This unit executes one 4-bit rotate instruction at a time against a shared scratch memory. An accepted instruction names an 11-bit source location, a 9-bit destination location, a rotate operation and an addressing mode. The unit reads one nibble from the source location, rotates it right or left by one to three places (or leaves it as it is), and writes the result to the destination location. It follows a fixed three-cycle sequence: read, then rotate, then write.

For table lookups driven by data, the addressing mode can replace the lowest four source address bits with the most recent result of one of three neighbouring operation units. The upper seven address bits still come from the instruction, so the instruction selects a 16-entry region and the neighbour's value selects the entry inside it. Operation codes whose top bit is clear, and the code `1000`, disable the unit for that instruction. In that case it does not touch the memory.

Top module: `nibble_rotor`

## Requirements
- R1: Instruction fields have fixed positions: destination address in bits 8:0, source address in bits 19:9, address mode in bits 43:42, and the 4-bit rotate code in bits 47:44. Bits 41:20 and bits 49:48 have no effect on any output.
- R2: An accepted instruction whose rotate code is `0xxx` or `1000` causes no read and no write, and `busy` stays low.
- R3: Codes `1001`, `1010` and `1011` write the operand rotated right (toward bit 0, with bit 0 wrapping to bit 3) by 1, 2 and 3 places.
- R4: Code `1100` writes the operand unchanged.
- R5: Codes `1101`, `1110` and `1111` write the operand rotated left (toward bit 3, with bit 3 wrapping to bit 0) by 1, 2 and 3 places.
- R6: Address mode `00` drives the source address from the instruction unchanged.
- R7: Address modes `01`, `10` and `11` replace source address bits 3:0 with `sib1_res`, `sib3_res` and `sib4_res` respectively, and keep bits 10:4 from the instruction.
- R8: The neighbour value used by R7 is the one present at the clock edge that accepts the instruction. Later changes to the neighbour inputs do not change the read address.
- R9: An instruction is accepted on a rising edge with `start` high and `busy` low. `rd_en` is high for the first cycle after acceptance, and `rd_data` is sampled at the end of that cycle. No access happens in the second cycle. `wr_en`, `wr_addr` and `wr_data` are valid in the third cycle. `busy` is high for those three cycles, and `start` is ignored while `busy` is high.
- R10: Synchronous active-high reset clears `busy`, `rd_en` and `wr_en` at the next edge, including in the middle of an instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Instruction present on `instr` |
| instr | input | 50 | Instruction fragment for this unit |
| sib1_res | input | 4 | Latest result of neighbour unit 1 |
| sib3_res | input | 4 | Latest result of neighbour unit 3 |
| sib4_res | input | 4 | Latest result of neighbour unit 4 |
| rd_data | input | 4 | Memory read data, valid while `rd_en` is high |
| busy | output | 1 | An instruction is in progress |
| rd_en | output | 1 | Memory read strobe |
| rd_addr | output | 11 | Memory read address |
| wr_en | output | 1 | Memory write strobe |
| wr_addr | output | 9 | Memory write address |
| wr_data | output | 4 | Memory write data |

## Verification
The bench builds the unit with its default sizes: a 4-bit data path, an 11-bit source address and a 9-bit destination address. At these sizes every one of the sixteen rotate codes and all four address modes can be driven, along with all-ones and all-zeros addresses at both ends of the memory. The rotator uses two log-stages at this width, so every combination of stage enables is exercised, including the left-by-zero case that wraps to a plain pass. The neighbour inputs are inverted right after acceptance, which shows that the address splice uses the value held at the accepting edge.

// File: rtl/nrot_pkg.sv
package nrot_pkg;

  // Instruction field layout
  localparam int OPC_W    = 4;
  localparam int MODE_W   = 2;
  localparam int NSIB     = 3;
  localparam int DST_LSB  = 0;
  localparam int SRC_LSB  = 9;
  localparam int MODE_LSB = 42;
  localparam int OPC_LSB  = 44;
  localparam int AMT_W    = 2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_ROT   = 2'd2,
    ST_WRITE = 2'd3
  } nrot_state_e;

  typedef struct packed {
    logic             en;
    logic             left;
    logic [AMT_W-1:0] amt;
  } nrot_op_t;

endpackage

// File: rtl/nrot_decode.sv
module nrot_decode
  import nrot_pkg::*;
(
  input  logic [OPC_W-1:0] code,
  output nrot_op_t         op
);

  // Top bit enables; the low three bits being zero also disables.
  // Bit 2 picks the direction, bits 1:0 give the distance.
  always_comb begin
    op.en   = code[OPC_W-1] & (|code[OPC_W-2:0]);
    op.left = code[2];
    op.amt  = code[AMT_W-1:0];
  end

endmodule

// File: rtl/nrot_srcsel.sv
module nrot_srcsel
  import nrot_pkg::*;
#(
  parameter int AW = 11,
  parameter int DW = 4
) (
  input  logic [AW-1:0]      base,
  input  logic [MODE_W-1:0]  mode,
  input  logic [NSIB*DW-1:0] sib_flat,
  output logic [AW-1:0]      addr
);

  // Mode 0 keeps the instruction address; mode k splices neighbour k-1
  always_comb begin
    addr = base;
    for (int i = 0; i < NSIB; i++) begin
      if (mode == MODE_W'(i + 1)) begin
        addr = {base[AW-1:DW], sib_flat[i*DW +: DW]};
      end
    end
  end

endmodule

// File: rtl/nrot_rotate.sv
module nrot_rotate
  import nrot_pkg::*;
#(
  parameter int DW = 4
) (
  input  logic [DW-1:0]    din,
  input  logic             left,
  input  logic [AMT_W-1:0] amt,
  output logic [DW-1:0]    dout
);

  localparam int EW = (DW > 1) ? $clog2(DW) : 1;

  // A left rotate by k is a right rotate by DW-k (modulo DW)
  logic [EW-1:0] eff;
  always_comb begin
    if (left) eff = EW'(DW - int'(amt));
    else      eff = EW'(amt);
  end

  logic [DW-1:0] stg [EW+1];
  assign stg[0] = din;

  for (genvar s = 0; s < EW; s++) begin : g_stage
    localparam int SH = 1 << s;
    assign stg[s+1] = eff[s] ? {stg[s][SH-1:0], stg[s][DW-1:SH]} : stg[s];
  end

  assign dout = stg[EW];

endmodule

// File: rtl/nibble_rotor.sv
module nibble_rotor
  import nrot_pkg::*;
#(
  parameter int DATA_W  = 4,
  parameter int SRC_AW  = 11,
  parameter int DST_AW  = 9,
  parameter int INSTR_W = 50
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [INSTR_W-1:0] instr,
  input  logic [DATA_W-1:0]  sib1_res,
  input  logic [DATA_W-1:0]  sib3_res,
  input  logic [DATA_W-1:0]  sib4_res,
  input  logic [DATA_W-1:0]  rd_data,
  output logic               busy,
  output logic               rd_en,
  output logic [SRC_AW-1:0]  rd_addr,
  output logic               wr_en,
  output logic [DST_AW-1:0]  wr_addr,
  output logic [DATA_W-1:0]  wr_data
);

  localparam int OPC_MSB = OPC_LSB + OPC_W - 1;
  localparam int SRC_MSB = SRC_LSB + SRC_AW - 1;

  // Field extraction
  logic [OPC_W-1:0]  code_in;
  logic [MODE_W-1:0] mode_in;
  logic [SRC_AW-1:0] src_in;
  logic [DST_AW-1:0] dst_in;
  logic [INSTR_W-OPC_MSB-2+MODE_LSB-SRC_MSB:0] unused_bits;

  assign code_in     = instr[OPC_LSB  +: OPC_W];
  assign mode_in     = instr[MODE_LSB +: MODE_W];
  assign src_in      = instr[SRC_LSB  +: SRC_AW];
  assign dst_in      = instr[DST_LSB  +: DST_AW];
  assign unused_bits = {instr[INSTR_W-1:OPC_MSB+1], instr[MODE_LSB-1:SRC_MSB+1]};

  nrot_op_t          dec_in;
  logic [SRC_AW-1:0] src_sel;

  nrot_decode u_dec (
    .code (code_in),
    .op   (dec_in)
  );

  nrot_srcsel #(
    .AW (SRC_AW),
    .DW (DATA_W)
  ) u_src (
    .base     (src_in),
    .mode     (mode_in),
    .sib_flat ({sib4_res, sib3_res, sib1_res}),
    .addr     (src_sel)
  );

  // Held instruction state
  nrot_state_e       state_q;
  nrot_op_t          op_q;
  logic [DST_AW-1:0] dst_q;
  logic [DATA_W-1:0] operand_q;
  logic [DATA_W-1:0] rot_out;

  nrot_rotate #(
    .DW (DATA_W)
  ) u_rot (
    .din  (operand_q),
    .left (op_q.left),
    .amt  (op_q.amt),
    .dout (rot_out)
  );

  logic accept;
  assign accept = start && (state_q == ST_IDLE) && dec_in.en;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      op_q      <= '0;
      dst_q     <= '0;
      operand_q <= '0;
      rd_en     <= 1'b0;
      rd_addr   <= '0;
      wr_en     <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          wr_en <= 1'b0;
          if (accept) begin
            state_q <= ST_READ;
            op_q    <= dec_in;
            dst_q   <= dst_in;
            rd_en   <= 1'b1;
            rd_addr <= src_sel;
          end
        end
        ST_READ: begin
          rd_en     <= 1'b0;
          operand_q <= rd_data;
          state_q   <= ST_ROT;
        end
        ST_ROT: begin
          wr_en   <= 1'b1;
          wr_addr <= dst_q;
          wr_data <= rot_out;
          state_q <= ST_WRITE;
        end
        ST_WRITE: begin
          wr_en   <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state_q != ST_IDLE);

endmodule

// File: rtl/nrot_chk.sv
module nrot_chk (
  input logic        clk,
  input logic        rst,
  input logic        start,
  input logic [49:0] instr,
  input logic [3:0]  sib1_res,
  input logic [3:0]  sib3_res,
  input logic [3:0]  sib4_res,
  input logic        busy,
  input logic        rd_en,
  input logic [10:0] rd_addr,
  input logic        wr_en,
  input logic [8:0]  wr_addr
);

  logic acc;
  logic go;
  logic [1:0] mode;
  assign acc  = start && !busy;
  assign go   = instr[47] && (instr[46:44] != 3'b000);
  assign mode = instr[43:42];

  a_r10_reset_quiet: assert property (@(posedge clk)
    rst |=> (!rd_en && !wr_en && !busy));

  a_r2_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
    (acc && !go) |=> (!rd_en && !busy));

  a_r9_read_first: assert property (@(posedge clk) disable iff (rst)
    (acc && go) |=> (rd_en && busy));

  a_r9_write_third: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> ##1 (wr_en && busy));

  a_r9_one_access: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && wr_en));

  a_r6_plain_addr: assert property (@(posedge clk) disable iff (rst)
    (acc && go && mode == 2'b00) |=> (rd_addr == $past(instr[19:9])));

  a_r7_splice_sib1: assert property (@(posedge clk) disable iff (rst)
    (acc && go && mode == 2'b01) |=>
      (rd_addr == {$past(instr[19:13]), $past(sib1_res)}));

  a_r7_splice_sib4: assert property (@(posedge clk) disable iff (rst)
    (acc && go && mode == 2'b11) |=>
      (rd_addr == {$past(instr[19:13]), $past(sib4_res)}));

  a_r1_dest_addr: assert property (@(posedge clk) disable iff (rst)
    (acc && go) |=> ##2 (wr_en && wr_addr == $past(instr[8:0], 3)));

endmodule

bind nibble_rotor nrot_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .instr    (instr),
  .sib1_res (sib1_res),
  .sib3_res (sib3_res),
  .sib4_res (sib4_res),
  .busy     (busy),
  .rd_en    (rd_en),
  .rd_addr  (rd_addr),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr)
);

// File: tb/nibble_rotor_tb.sv
module nibble_rotor_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [49:0] instr = '0;
  logic [3:0]  sib1_res = '0;
  logic [3:0]  sib3_res = '0;
  logic [3:0]  sib4_res = '0;
  logic [3:0]  rd_data;
  logic        busy;
  logic        rd_en;
  logic [10:0] rd_addr;
  logic        wr_en;
  logic [8:0]  wr_addr;
  logic [3:0]  wr_data;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Memory model: contents are a function of the address
  function automatic logic [3:0] mem_val(input logic [10:0] a);
    return 4'(a[3:0] * 4'd5 + a[7:4] + {1'b0, a[10:8]});
  endfunction
  assign rd_data = mem_val(rd_addr);

  nibble_rotor u_dut (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .instr    (instr),
    .sib1_res (sib1_res),
    .sib3_res (sib3_res),
    .sib4_res (sib4_res),
    .rd_data  (rd_data),
    .busy     (busy),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data)
  );

  // Vector layout: code[49:46] mode[45:44] src[43:33] dst[32:24] filler[23:0]
  localparam logic [49:0] VECS [NVEC] = '{
    {4'b1001, 2'b00, 11'h5A3, 9'h012, 24'h000000},
    {4'b1010, 2'b01, 11'h7FF, 9'h1FF, 24'hFFFFFF},
    {4'b1011, 2'b10, 11'h000, 9'h100, 24'h555555},
    {4'b1100, 2'b11, 11'h2C7, 9'h0AA, 24'hAAAAAA},
    {4'b1101, 2'b00, 11'h400, 9'h001, 24'hC00000},
    {4'b1110, 2'b01, 11'h13B, 9'h0F0, 24'h123456},
    {4'b1111, 2'b11, 11'h6E9, 9'h155, 24'h3FFFFF},
    {4'b1000, 2'b01, 11'h111, 9'h0C3, 24'h000000},
    {4'b0110, 2'b00, 11'h222, 9'h044, 24'hFFFFFF},
    {4'b0000, 2'b11, 11'h333, 9'h199, 24'h0F0F0F}
  };

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] ref_rot(input logic [3:0] x, input logic [3:0] code);
    logic [3:0] y;
    y = x;
    if (code == 4'b1100) return y;
    for (int k = 0; k < int'(code[1:0]); k++) begin
      if (code[2]) y = {y[2:0], y[3]};
      else         y = {y[0], y[3:1]};
    end
    return y;
  endfunction

  function automatic string rot_req(input logic [3:0] code);
    if (code == 4'b1100) return "R4";
    if (code[2])         return "R5";
    return "R3";
  endfunction

  task automatic run_op(input logic [3:0] code, input logic [1:0] mode,
                        input logic [10:0] src, input logic [8:0] dst,
                        input logic [23:0] fill, input logic [3:0] s1,
                        input logic [3:0] s3, input logic [3:0] s4,
                        input bit poke);
    logic [10:0] exp_addr;
    logic [3:0]  sel;
    logic [3:0]  exp_data;
    bit          en;
    string       areq;
    en  = code[3] && (code[2:0] != 3'b000);
    sel = (mode == 2'b01) ? s1 : (mode == 2'b10) ? s3 : s4;
    exp_addr = (mode == 2'b00) ? src : {src[10:4], sel};
    areq = (mode == 2'b00) ? "R6" : "R7/R8";
    exp_data = ref_rot(mem_val(exp_addr), code);

    @(negedge clk);
    start = 1'b1;
    instr = {fill[23:22], code, mode, fill[21:0], src, dst};
    sib1_res = s1; sib3_res = s3; sib4_res = s4;
    @(posedge clk);
    #1;
    start = 1'b0;
    instr = ~instr;
    sib1_res = ~s1; sib3_res = ~s3; sib4_res = ~s4;   // R8: later changes ignored

    @(negedge clk);
    if (en) begin
      check(rd_en === 1'b1 && busy === 1'b1, "R9 read cycle", {rd_en, busy}, 2'b11);
      check(rd_addr === exp_addr, areq, rd_addr, exp_addr);
    end else begin
      check(rd_en === 1'b0 && busy === 1'b0 && wr_en === 1'b0, "R2 no read",
            {rd_en, busy, wr_en}, 3'b000);
    end
    if (poke) begin
      start = 1'b1;
      instr = {2'b00, 4'b1001, 2'b00, 22'h0, 11'h7AA, 9'h0BB};
    end

    @(negedge clk);
    check(rd_en === 1'b0 && wr_en === 1'b0, "R9 idle middle cycle",
          {rd_en, wr_en}, 2'b00);

    @(negedge clk);
    if (en) begin
      check(wr_en === 1'b1, "R9 write cycle", wr_en, 1'b1);
      check(wr_addr === dst, "R1 destination", wr_addr, dst);
      check(wr_data === exp_data, rot_req(code), wr_data, exp_data);
    end else begin
      check(wr_en === 1'b0, "R2 no write", wr_en, 1'b0);
    end
    start = 1'b0;

    @(negedge clk);
    check(rd_en === 1'b0 && wr_en === 1'b0 && busy === 1'b0, "R9 end, start ignored while busy",
          {rd_en, wr_en, busy}, 3'b000);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual running expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R10: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(busy === 1'b0 && rd_en === 1'b0 && wr_en === 1'b0, "R10 reset",
          {busy, rd_en, wr_en}, 3'b000);
    rst = 1'b0;

    // Table walk (R1 filler bits, R3, R4, R5, R6, R7, R8, R2)
    for (int i = 0; i < NVEC; i++) begin
      run_op(VECS[i][49:46], VECS[i][45:44], VECS[i][43:33], VECS[i][32:24],
             VECS[i][23:0], 4'(i*3 + 1), 4'(i*5 + 2), 4'(i*7 + 9), 1'b0);
    end

    // R9: start held high during a busy instruction is ignored
    run_op(4'b1101, 2'b10, 11'h3F0, 9'h077, 24'h0, 4'h6, 4'hD, 4'h2, 1'b1);

    // R7: each neighbour selects its own value, same upper bits
    run_op(4'b1011, 2'b01, 11'h7F3, 9'h00F, 24'h0, 4'hE, 4'h1, 4'h7, 1'b0);
    run_op(4'b1011, 2'b10, 11'h7F3, 9'h00F, 24'h0, 4'hE, 4'h1, 4'h7, 1'b0);
    run_op(4'b1011, 2'b11, 11'h7F3, 9'h00F, 24'h0, 4'hE, 4'h1, 4'h7, 1'b0);

    // R10: reset in the middle of an instruction
    @(negedge clk);
    start = 1'b1;
    instr = {2'b00, 4'b1110, 2'b00, 22'h0, 11'h0A5, 9'h033};
    @(posedge clk);
    #1 start = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(busy === 1'b0 && rd_en === 1'b0 && wr_en === 1'b0, "R10 mid-op reset",
          {busy, rd_en, wr_en}, 3'b000);
    @(negedge clk);
    check(wr_en === 1'b0, "R10 no late write", wr_en, 1'b0);
    rst = 1'b0;

    // Recovery after reset
    run_op(4'b1001, 2'b00, 11'h0FF, 9'h1AB, 24'h0, 4'h0, 4'h0, 4'h0, 1'b0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule